// File: doc/BRIEF.md
# Capture-Compare Timer with Match Outputs

This block is a 16-bit free-running counter shared by four capture channels and three compare channels. The counter steps either on a programmable divided-down version of the system clock or on rising edges of an external event pin. A rising edge on an external clear pin can force it back to zero when that clear is enabled. Each capture channel copies the counter into its own register when its input shows the edge chosen for that channel. The compare channels drive eight outputs. Compare 0 sets any of six level outputs, and compare 1 clears them, each under its own enable bit. Compare 2 inverts either of two toggle outputs, again under an enable bit.

A host programs the block through a one-cycle write strobe with a 4-bit address, and reads any register combinationally on the same address. Every capture event, every compare match and every counter wrap sets a sticky flag. A flag stays set until the host writes a 1 to its bit. The OR of the flags drives one interrupt line. All external pins pass through a two-flop synchroniser before their edges are detected.

Register map (16-bit words):

| Addr | Contents |
|------|----------|
| 0 | control: bit0 run, bit1 event source (0 divided clock, 1 event pin), bit2 external-clear enable, bits 7:4 divider limit D |
| 1 | edge select: two bits per capture channel c at bits 2c+1:2c, codes 0 off, 1 rising, 2 falling, 3 both |
| 2 | set enables, bit i for level output i |
| 3 | clear enables, bit i for level output i |
| 4 | toggle enables, bit j for toggle output j |
| 5, 6, 7 | compare values 0, 1, 2 |
| 8 to 11 | capture values 0 to 3 (read only) |
| 12 | counter (read only) |
| 13 | flags: bits 3:0 capture 0 to 3, bits 6:4 compare 0 to 2, bit 7 wrap; a written 1 clears the bit |

Top module: `cct_top`

## Requirements
- R1: In divided-clock mode with run set, the counter advances by one every D+1 clock cycles; the first step comes D+1 cycles after run is written, and the counter holds while run is clear.
- R2: In event mode with run set, the counter advances by one for each rising edge seen on the event pin after synchronisation. Nothing else moves it.
- R3: With external clear enabled, a rising edge on the clear pin sets the counter to 0, whether or not the counter runs. Clear takes priority over a step. A clear pin held high or falling has no effect.
- R4: A capture channel copies the counter value of the cycle in which its synchronised input shows the selected edge (code 1 rising, 2 falling, 3 both, 0 never), and sets its flag (flags bit c).
- R5: A match of compare 0 drives each level output whose set enable is 1 high. A match of compare 1 drives each level output whose clear enable is 1 low. When both act on the same output in the same cycle, the output goes low.
- R6: A match of compare 2 inverts each toggle output whose toggle enable is 1.
- R7: A compare is evaluated only in the cycle after the counter takes a new value, by a step or a clear. A counter that stands still, or a compare value rewritten while the counter stands still, causes no match.
- R8: On a step from 0xFFFF the counter becomes 0x0000 and the wrap flag (flags bit 7) is set.
- R9: Each flag stays set until a 1 is written to its bit at address 13. A written 0 leaves it unchanged, and a new event in the same cycle as a clear keeps it set.
- R10: After reset, all registers, flags, the counter and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| wr_en | input | 1 | host write strobe, one cycle per write |
| addr | input | 4 | host register address |
| wdata | input | 16 | host write data |
| rdata | output | 16 | read data for addr, combinational |
| cap_in | input | 4 | capture inputs, one per channel |
| evt_in | input | 1 | external event input for counting |
| xclr_in | input | 1 | external counter clear input |
| lvl_out | output | 6 | set/clear match outputs |
| tog_out | output | 2 | toggle match outputs |
| flags | output | 8 | sticky event flags |
| irq | output | 1 | OR of all flags |

## Verification
A wrong counter value shows up on the counter readback in the cycle it occurs. It also shows up one cycle later as a match outputs or flags that are missing or extra. A bad capture register stays wrong until the next edge on that channel. A stuck or wrongly cleared flag shows on the flag port and on irq within one cycle. Because toggle outputs keep their parity, a single missed or doubled toggle remains visible until the next match of compare 2. That is why every output is compared in every cycle and not only at scenario ends.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam logic [3:0] A_CTRL  = 4'd0;
  localparam logic [3:0] A_EDGE  = 4'd1;
  localparam logic [3:0] A_SETEN = 4'd2;
  localparam logic [3:0] A_RSTEN = 4'd3;
  localparam logic [3:0] A_TOGEN = 4'd4;
  localparam logic [3:0] A_CMP0  = 4'd5;
  localparam logic [3:0] A_CMP1  = 4'd6;
  localparam logic [3:0] A_CMP2  = 4'd7;
  localparam logic [3:0] A_CAP0  = 4'd8;
  localparam logic [3:0] A_COUNT = 4'd12;
  localparam logic [3:0] A_FLAGS = 4'd13;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_sel_e;

  function automatic logic edge_hit(input logic [1:0] sel, input logic rise, input logic fall);
    case (edge_sel_e'(sel))
      EDGE_RISE: edge_hit = rise;
      EDGE_FALL: edge_hit = fall;
      EDGE_BOTH: edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  endfunction

  function automatic logic lvl_next(input logic cur, input logic set_hit, input logic clr_hit);
    if (clr_hit)      lvl_next = 1'b0;
    else if (set_hit) lvl_next = 1'b1;
    else              lvl_next = cur;
  endfunction
endpackage

// File: rtl/cct_sync_edge.sv
module cct_sync_edge #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [2:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[1:0], din[g]};
    end
    assign rise[g] = sh[1] & ~sh[2];
    assign fall[g] = ~sh[1] & sh[2];
  end
endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             evt_sel,
  input  logic             clr_en,
  input  logic [PRE_W-1:0] pre_lim,
  input  logic             evt_rise,
  input  logic             xclr_rise,
  output logic [CNT_W-1:0] count,
  output logic             tick,
  output logic             clr,
  output logic             upd,
  output logic             wrap
);
  logic [PRE_W-1:0] presc;
  logic             pre_done;

  assign pre_done = (presc == pre_lim);
  assign tick     = run & (evt_sel ? evt_rise : pre_done);
  assign clr      = clr_en & xclr_rise;
  assign wrap     = tick & ~clr & (count == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       presc <= '0;
    else if (!run || evt_sel || clr)  presc <= '0;
    else if (pre_done)                presc <= '0;
    else                              presc <= presc + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      upd   <= 1'b0;
    end else begin
      upd <= tick | clr;
      if (clr)       count <= '0;
      else if (tick) count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/cct_capture.sv
module cct_capture #(
  parameter int N_CAP = 4,
  parameter int CNT_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [2*N_CAP-1:0]          edge_cfg,
  input  logic [N_CAP-1:0]            rise,
  input  logic [N_CAP-1:0]            fall,
  input  logic [CNT_W-1:0]            count,
  output logic [N_CAP-1:0]            cap_hit,
  output logic [N_CAP-1:0][CNT_W-1:0] cap_val
);
  import cct_pkg::*;
  for (genvar c = 0; c < N_CAP; c++) begin : g_ch
    assign cap_hit[c] = edge_hit(edge_cfg[2*c +: 2], rise[c], fall[c]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cap_val[c] <= '0;
      else if (cap_hit[c]) cap_val[c] <= count;
    end
  end
endmodule

// File: rtl/cct_compare.sv
module cct_compare #(
  parameter int CNT_W = 16,
  parameter int N_SR  = 6,
  parameter int N_TG  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             upd,
  input  logic [CNT_W-1:0] cmp0,
  input  logic [CNT_W-1:0] cmp1,
  input  logic [CNT_W-1:0] cmp2,
  input  logic [N_SR-1:0]  seten,
  input  logic [N_SR-1:0]  rsten,
  input  logic [N_TG-1:0]  togen,
  output logic [2:0]       match,
  output logic [N_SR-1:0]  lvl_out,
  output logic [N_TG-1:0]  tog_out
);
  import cct_pkg::*;
  assign match[0] = upd & (count == cmp0);
  assign match[1] = upd & (count == cmp1);
  assign match[2] = upd & (count == cmp2);

  for (genvar i = 0; i < N_SR; i++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_out[i] <= 1'b0;
      else        lvl_out[i] <= lvl_next(lvl_out[i], match[0] & seten[i], match[1] & rsten[i]);
    end
  end

  for (genvar j = 0; j < N_TG; j++) begin : g_tog
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       tog_out[j] <= 1'b0;
      else if (match[2] && togen[j])    tog_out[j] <= ~tog_out[j];
    end
  end
endmodule

// File: rtl/cct_top.sv
module cct_top #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 4,
  parameter int N_CAP = 4,
  parameter int N_SR  = 6,
  parameter int N_TG  = 2,
  parameter int FLG_W = N_CAP + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  input  logic [N_CAP-1:0] cap_in,
  input  logic             evt_in,
  input  logic             xclr_in,
  output logic [N_SR-1:0]  lvl_out,
  output logic [N_TG-1:0]  tog_out,
  output logic [FLG_W-1:0] flags,
  output logic             irq
);
  import cct_pkg::*;
  localparam int N_IN = N_CAP + 2;

  logic [CNT_W-1:0] ctrl_q, edge_q, seten_q, rsten_q, togen_q;
  logic [CNT_W-1:0] cmp0_q, cmp1_q, cmp2_q;
  logic [N_IN-1:0]  in_rise, in_fall;
  logic [CNT_W-1:0] count;
  logic             tick, clr, upd, wrap;
  logic [N_CAP-1:0] cap_hit;
  logic [N_CAP-1:0][CNT_W-1:0] cap_val;
  logic [2:0]       match;
  logic [FLG_W-1:0] flg_set, flg_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; edge_q <= '0; seten_q <= '0; rsten_q <= '0;
      togen_q <= '0; cmp0_q <= '0; cmp1_q <= '0; cmp2_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL:  ctrl_q  <= wdata;
        A_EDGE:  edge_q  <= wdata;
        A_SETEN: seten_q <= wdata;
        A_RSTEN: rsten_q <= wdata;
        A_TOGEN: togen_q <= wdata;
        A_CMP0:  cmp0_q  <= wdata;
        A_CMP1:  cmp1_q  <= wdata;
        A_CMP2:  cmp2_q  <= wdata;
        default: ;
      endcase
    end
  end

  cct_sync_edge #(.W(N_IN)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({xclr_in, evt_in, cap_in}),
    .rise(in_rise), .fall(in_fall)
  );

  cct_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .run(ctrl_q[0]), .evt_sel(ctrl_q[1]), .clr_en(ctrl_q[2]),
    .pre_lim(ctrl_q[PRE_W+3:4]),
    .evt_rise(in_rise[N_CAP]), .xclr_rise(in_rise[N_CAP+1]),
    .count(count), .tick(tick), .clr(clr), .upd(upd), .wrap(wrap)
  );

  cct_capture #(.N_CAP(N_CAP), .CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .edge_cfg(edge_q[2*N_CAP-1:0]),
    .rise(in_rise[N_CAP-1:0]), .fall(in_fall[N_CAP-1:0]),
    .count(count), .cap_hit(cap_hit), .cap_val(cap_val)
  );

  cct_compare #(.CNT_W(CNT_W), .N_SR(N_SR), .N_TG(N_TG)) u_cmp (
    .clk(clk), .rst_n(rst_n),
    .count(count), .upd(upd),
    .cmp0(cmp0_q), .cmp1(cmp1_q), .cmp2(cmp2_q),
    .seten(seten_q[N_SR-1:0]), .rsten(rsten_q[N_SR-1:0]), .togen(togen_q[N_TG-1:0]),
    .match(match), .lvl_out(lvl_out), .tog_out(tog_out)
  );

  assign flg_set = {wrap, match, cap_hit};
  assign flg_clr = (wr_en && addr == A_FLAGS) ? wdata[FLG_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~flg_clr) | flg_set;
  end

  assign irq = |flags;

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata = ctrl_q;
      A_EDGE:  rdata = edge_q;
      A_SETEN: rdata = seten_q;
      A_RSTEN: rdata = rsten_q;
      A_TOGEN: rdata = togen_q;
      A_CMP0:  rdata = cmp0_q;
      A_CMP1:  rdata = cmp1_q;
      A_CMP2:  rdata = cmp2_q;
      A_COUNT: rdata = count;
      A_FLAGS: rdata = CNT_W'(flags);
      default: begin
        for (int c = 0; c < N_CAP; c++)
          if (addr == A_CAP0 + 4'(c)) rdata = cap_val[c];
      end
    endcase
  end
endmodule

// File: rtl/cct_checker.sv
module cct_checker #(
  parameter int CNT_W = 16,
  parameter int N_SR  = 6,
  parameter int N_TG  = 2,
  parameter int FLG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [3:0]       addr,
  input logic [CNT_W-1:0] wdata,
  input logic [CNT_W-1:0] count,
  input logic             tick,
  input logic             clr,
  input logic [2:0]       match,
  input logic [N_SR-1:0]  rsten,
  input logic [N_TG-1:0]  togen,
  input logic [N_SR-1:0]  lvl_out,
  input logic [N_TG-1:0]  tog_out,
  input logic [FLG_W-1:0] flags
);
  logic [FLG_W-1:0] keep;
  assign keep = (wr_en && addr == 4'd13) ? (flags & ~wdata[FLG_W-1:0]) : flags;

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr) |=> count == CNT_W'($past(count) + 1'b1)); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(count)); // R2
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0); // R3
  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    match[1] |=> (lvl_out & $past(rsten)) == '0); // R5
  AST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    match[2] |=> tog_out == $past(tog_out ^ togen)); // R6
  AST_NO_MATCH_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (match == 3'b000) |=> ($stable(lvl_out) && $stable(tog_out))); // R7
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && count == {CNT_W{1'b1}}) |=> flags[FLG_W-1]); // R8
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (flags & $past(keep)) == $past(keep)); // R9
endmodule

bind cct_top cct_checker #(.CNT_W(CNT_W), .N_SR(N_SR), .N_TG(N_TG), .FLG_W(FLG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .count(count), .tick(tick), .clr(clr), .match(match),
  .rsten(rsten_q[N_SR-1:0]), .togen(togen_q[N_TG-1:0]),
  .lvl_out(lvl_out), .tog_out(tog_out), .flags(flags)
);

// File: tb/cct_top_tb_top.sv
module cct_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic [3:0]  cap_in = 4'd0;
  logic        evt_in = 1'b0;
  logic        xclr_in = 1'b0;
  logic [5:0]  lvl_out;
  logic [1:0]  tog_out;
  logic [7:0]  flags;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cct_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cap_in(cap_in), .evt_in(evt_in), .xclr_in(xclr_in),
    .lvl_out(lvl_out), .tog_out(tog_out), .flags(flags), .irq(irq)
  );

  // reference model state
  int   m_cnt, m_pre;
  int   m_reg [0:7];
  int   m_cap [0:3];
  bit   s1 [0:5];
  bit   s2 [0:5];
  bit   pv [0:5];
  bit   m_upd;
  bit   [7:0] m_flags;
  bit   [5:0] m_lvl;
  bit   [1:0] m_tog;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_upd = 0; m_flags = 0; m_lvl = 0; m_tog = 0;
      for (int i = 0; i < 8; i++) m_reg[i] = 0;
      for (int i = 0; i < 4; i++) m_cap[i] = 0;
      for (int i = 0; i < 6; i++) begin s1[i] = 0; s2[i] = 0; pv[i] = 0; end
    end else begin
      bit run, esel, cen, tick, clr, wrap;
      bit rs [0:5];
      bit fl [0:5];
      bit [2:0] mt;
      bit [7:0] setv, clrv;
      int plim;
      for (int i = 0; i < 6; i++) begin rs[i] = s2[i] && !pv[i]; fl[i] = !s2[i] && pv[i]; end
      run = m_reg[0][0]; esel = m_reg[0][1]; cen = m_reg[0][2]; plim = (m_reg[0] >> 4) & 15;
      tick = run && (esel ? rs[4] : (m_pre == plim));
      clr  = cen && rs[5];
      wrap = tick && !clr && m_cnt == 65535;
      for (int k = 0; k < 3; k++) mt[k] = m_upd && (m_cnt == m_reg[5+k]);
      setv = 0;
      for (int c = 0; c < 4; c++) begin
        int code;
        bit hit;
        code = (m_reg[1] >> (2*c)) & 3;
        hit = (code == 1 && rs[c]) || (code == 2 && fl[c]) || (code == 3 && (rs[c] || fl[c]));
        if (hit) begin m_cap[c] = m_cnt; setv[c] = 1; end
      end
      setv[6:4] = mt; setv[7] = wrap;
      for (int i = 0; i < 6; i++) begin
        if (mt[1] && m_reg[3][i]) m_lvl[i] = 0;
        else if (mt[0] && m_reg[2][i]) m_lvl[i] = 1;
      end
      for (int j = 0; j < 2; j++) if (mt[2] && m_reg[4][j]) m_tog[j] = ~m_tog[j];
      clrv = (wr_en && addr == 4'd13) ? wdata[7:0] : 8'd0;
      m_flags = (m_flags & ~clrv) | setv;
      if (wr_en && addr < 4'd8) m_reg[addr] = wdata;
      if (!run || esel || clr || m_pre == plim) m_pre = 0; else m_pre++;
      m_upd = tick || clr;
      if (clr) m_cnt = 0; else if (tick) m_cnt = (m_cnt + 1) % 65536;
      for (int i = 0; i < 6; i++) begin pv[i] = s2[i]; s2[i] = s1[i]; end
      for (int i = 0; i < 4; i++) s1[i] = cap_in[i];
      s1[4] = evt_in; s1[5] = xclr_in;
    end
  end

  function automatic int model_read(input logic [3:0] a);
    if (a < 4'd8) return m_reg[a] & 16'hFFFF;
    if (a < 4'd12) return m_cap[a-8];
    if (a == 4'd12) return m_cnt;
    if (a == 4'd13) return m_flags;
    return 0;
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R5 lvl_out", lvl_out, m_lvl);
      check("R6 tog_out", tog_out, m_tog);
      check("R9 flags", flags, m_flags);
      check("R9 irq", irq, (m_flags != 0));
      check("R1 rdata", rdata, model_read(addr));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(posedge clk); #2; wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #2; wr_en = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input int exp);
    @(posedge clk); #2; addr = a;
    @(negedge clk); check(tag, rdata, exp);
  endtask

  task automatic evt_pulse(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #2; evt_in = 1;
      repeat (2) @(posedge clk); #2; evt_in = 0;
      repeat (2) @(posedge clk);
    end
    repeat (5) @(posedge clk);
  endtask

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    // R10 reset state
    check("R10 lvl_out", lvl_out, 0);
    check("R10 tog_out", tog_out, 0);
    check("R10 flags", flags, 0);
    rd_chk("R10 count", 4'd12, 0);
    rd_chk("R10 ctrl", 4'd0, 0);
    rd_chk("R10 cap0", 4'd8, 0);

    // R1 divided clock, limit 2 -> step every 3 cycles, 10 steps
    wr(4'd0, 16'h0021);
    repeat (28) @(posedge clk);
    wr(4'd0, 16'h0020);
    rd_chk("R1 count after divided run", 4'd12, 10);
    repeat (10) @(posedge clk);
    rd_chk("R1 count holds when stopped", 4'd12, 10);

    // R2 event mode, five pulses
    wr(4'd0, 16'h0003);
    evt_pulse(5);
    rd_chk("R2 count after events", 4'd12, 15);

    // R3 external clear, only on a rising edge
    wr(4'd0, 16'h0004);
    @(posedge clk); #2 xclr_in = 1;
    repeat (8) @(posedge clk);
    rd_chk("R3 count cleared while stopped", 4'd12, 0);
    wr(4'd0, 16'h0007);
    evt_pulse(3);
    rd_chk("R3 held-high clear ignored", 4'd12, 3);
    @(posedge clk); #2 xclr_in = 0;
    repeat (6) @(posedge clk);
    rd_chk("R3 falling clear ignored", 4'd12, 3);

    // R4 capture edge codes: ch0 rise, ch1 fall, ch2 both, ch3 off
    wr(4'd0, 16'h0003);
    wr(4'd1, 16'h0039);
    @(posedge clk); #2 cap_in = 4'hF;
    repeat (6) @(posedge clk);
    rd_chk("R4 flags after rising", 4'd13, 8'h75);
    rd_chk("R4 cap0 rising", 4'd8, 3);
    evt_pulse(2);
    @(posedge clk); #2 cap_in = 4'h0;
    repeat (6) @(posedge clk);
    rd_chk("R4 cap0 unchanged on fall", 4'd8, 3);
    rd_chk("R4 cap1 falling", 4'd9, 5);
    rd_chk("R4 cap2 both", 4'd10, 5);
    rd_chk("R4 cap3 off", 4'd11, 0);
    rd_chk("R4 flags after falling", 4'd13, 8'h77);

    // R9 write-one-to-clear
    wr(4'd13, 16'h0071);
    rd_chk("R9 flags after w1c", 4'd13, 8'h06);
    wr(4'd13, 16'h0000);
    rd_chk("R9 zero write keeps flags", 4'd13, 8'h06);

    // R5 set / clear outputs
    wr(4'd5, 16'd8);
    wr(4'd6, 16'd10);
    wr(4'd2, 16'h003F);
    wr(4'd3, 16'h000F);
    evt_pulse(3);
    @(negedge clk); check("R5 set at compare 0", lvl_out, 6'h3F);
    evt_pulse(2);
    @(negedge clk); check("R5 clear at compare 1", lvl_out, 6'h30);
    wr(4'd5, 16'd12);
    wr(4'd6, 16'd12);
    evt_pulse(2);
    @(negedge clk); check("R5 clear wins over set", lvl_out, 6'h30);

    // R6 toggle
    wr(4'd7, 16'd13);
    wr(4'd4, 16'h0001);
    evt_pulse(1);
    @(negedge clk); check("R6 toggle at compare 2", tog_out, 2'b01);

    // R7 no match while counter stands still
    repeat (20) @(posedge clk);
    @(negedge clk); check("R7 no retrigger when still", tog_out, 2'b01);
    wr(4'd4, 16'h0003);
    wr(4'd7, 16'd13);
    repeat (5) @(posedge clk);
    @(negedge clk); check("R7 rewrite while still no match", tog_out, 2'b01);

    // R8 wrap with divide-by-one clock
    wr(4'd0, 16'h0001);
    repeat (65545) @(posedge clk);
    wr(4'd0, 16'h0000);
    @(posedge clk); #2 addr = 4'd13;
    @(negedge clk); check("R8 wrap flag", rdata[7], 1);
    check("R6 toggle after wrap", tog_out, 2'b10);
    check("R5 outputs after wrap", lvl_out, 6'h30);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule